// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable single-port synchronous SRAM with a burst address counter and a registered read pipeline. Each word holds four byte lanes, and each lane is nine bits wide. A burst starts when either of two address strobes is asserted. The processor-side strobe is honoured only while the master chip select is low. The controller-side strobe is always honoured. After a burst has started, the advance input steps through a four-word block, in interleaved or linear order. Holding advance high suspends the burst on the current word.

Writes take effect on the same clock edge as the cycle that carries them. A global write enable writes all four lanes. When it is high, a byte-write enable passes per-lane enables through. A cycle that writes no lane is a read. Read data leaves the array register one clock after the cycle's address is captured. The data bus is modelled as separate input and output vectors plus a drive-enable. The drive-enable follows the output-enable pin and the sleep pin without waiting for a clock. While the sleep pin is high, every other input is ignored, the bus is released and any burst in progress is abandoned. The array contents are kept.

Top module: `sync_burst_sram`

## Requirements
- R1: A read cycle that loads address A is a cycle in which the controller strobe is low, or the processor strobe is low with cs_n low, while the chip is selected (cs_n=0, cs_hi=1, cs_lo_n=0). After it, dq_oe is 1 and dq_out is the word at A, in the clock period after the second rising edge.
- R2: A strobe that loads while the chip is not selected ends any burst. That cycle produces no read data, and later cycles produce none until a new selected load.
- R3: While cs_n is high, the processor strobe has no effect: a burst in progress continues as if no strobe were present.
- R4: In a burst with no strobe, adv_n=0 moves to the next burst address, and adv_n=1 repeats the current address. The address bits above the low two never change within a burst.
- R5: With burst_ileave=1, the word accessed at burst step i (0..3) has low two address bits equal to base[1:0] XOR i.
- R6: With burst_ileave=0, the word accessed at burst step i has low two address bits equal to (base[1:0]+i) mod 4.
- R7: wr_all_n=0 writes dq_in into all four lanes. Lane k occupies bits [9k+8:9k].
- R8: With wr_all_n=1 and wr_lane_en_n=0, lane k is written exactly when lane_we_n[k]=0, and the other lanes keep their contents. If every lane_we_n bit is 1, the cycle is a read.
- R9: With wr_all_n=1 and wr_lane_en_n=1, the cycle is a read whatever the value of lane_we_n.
- R10: A write cycle produces no read data: dq_oe stays 0 in the slot where that cycle's data would appear.
- R11: dq_oe falls as soon as oe_n rises and returns as soon as oe_n falls, with no clock edge in between.
- R12: While sleep=1, dq_oe is 0 at once and writes are ignored. After sleep falls, no burst continues, and all stored words are unchanged.
- R13: After reset, dq_oe is 0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset of the control pipeline |
| addr | input | ADDR_W | Word address, captured on a load |
| strobe_p_n | input | 1 | Processor-side address strobe, active low, gated by cs_n |
| strobe_c_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs_n | input | 1 | Master chip select, active low |
| cs_hi | input | 1 | Secondary chip select, active high |
| cs_lo_n | input | 1 | Secondary chip select, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_lane_en_n | input | 1 | Enables the per-lane write enables, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_ileave | input | 1 | 1 selects interleaved burst order, 0 selects linear |
| sleep | input | 1 | Asynchronous low-power request, active high |
| dq_in | input | LANES*LANE_W | Write data |
| dq_out | output | LANES*LANE_W | Read data |
| dq_oe | output | 1 | Bus drive-enable |

## Verification
If the burst counter or the stored burst base goes wrong, the block reads the wrong word. That wrong word reaches dq_out one clock after the faulty step, so each burst step is compared against a computed address. A stale selection flag shows up as dq_oe high in a slot where a deselect or a sleep period should have left it low. A write-enable decode error stays hidden until the word is read back. For that reason, every lane mask is written and then read through the array.

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    strobe_p_n,
  input  logic                    strobe_c_n,
  input  logic                    adv_n,
  input  logic                    cs_n,
  input  logic                    cs_hi,
  input  logic                    cs_lo_n,
  input  logic                    wr_all_n,
  input  logic                    wr_lane_en_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic                    oe_n,
  input  logic                    burst_ileave,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              active, rd_q, rdv;
  logic [ADDR_W-1:0] base, a_q;
  logic [1:0]        cnt, cnt_nx, low;
  logic [DATA_W-1:0] dout;
  logic [ADDR_W-1:0] org, cyc_addr;
  logic [LANES-1:0]  lane_wr;
  logic              p_go, load, sel, start, run, live, wr;

  assign p_go  = !strobe_p_n && !cs_n;
  assign load  = p_go || !strobe_c_n;
  assign sel   = !cs_n && cs_hi && !cs_lo_n;
  assign start = load && sel;
  assign run   = !load && active;
  assign live  = !sleep && (start || run);

  assign cnt_nx   = start ? 2'd0 : (run && !adv_n) ? cnt + 2'd1 : cnt;
  assign org      = start ? addr : base;
  assign low      = burst_ileave ? (org[1:0] ^ cnt_nx) : (org[1:0] + cnt_nx);
  assign cyc_addr = {org[ADDR_W-1:2], low};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_wr[i] = live && (!wr_all_n || (!wr_lane_en_n && !lane_we_n[i]));
  end
  assign wr = |lane_wr;

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (lane_wr[i]) mem[cyc_addr][i*LANE_W +: LANE_W] <= dq_in[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      rd_q   <= 1'b0;
      rdv    <= 1'b0;
      cnt    <= '0;
      base   <= '0;
      a_q    <= '0;
      dout   <= '0;
    end else if (sleep) begin
      active <= 1'b0;
      rd_q   <= 1'b0;
      rdv    <= 1'b0;
    end else begin
      if (load)  active <= sel;
      if (start) base <= addr;
      cnt <= cnt_nx;
      if (live)  a_q <= cyc_addr;
      rd_q <= live && !wr;
      rdv  <= rd_q;
      if (rd_q)  dout <= mem[a_q];
    end
  end

  assign dq_out = dout;
  assign dq_oe  = rdv && !oe_n && !sleep;

  p_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_c_n && cs_n && !sleep) |=> !active);

  p_pstrobe_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && strobe_c_n && cs_n && !sleep) |=> !active);

  p_burst_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && strobe_c_n && (strobe_p_n || cs_n) && !sleep)
      |=> (a_q[ADDR_W-1:2] == $past(base[ADDR_W-1:2])));

  p_write_nodata_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_all_n && !sleep) |=> !rd_q);

  p_sleep_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!rdv && !active));
endmodule

// File: tb/sync_burst_sram_test.sv
module sync_burst_sram_test;
  localparam int AW = 6;
  localparam int DW = 36;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr;
  logic strobe_p_n, strobe_c_n, adv_n, cs_n, cs_hi, cs_lo_n;
  logic wr_all_n, wr_lane_en_n, oe_n, burst_ileave, sleep;
  logic [3:0] lane_we_n;
  logic [DW-1:0] dq_in, dq_out;
  logic dq_oe;
  logic [DW-1:0] model [64];
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sync_burst_sram uut (.clk(clk), .rst_n(rst_n), .addr(addr), .strobe_p_n(strobe_p_n),
    .strobe_c_n(strobe_c_n), .adv_n(adv_n), .cs_n(cs_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
    .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n), .lane_we_n(lane_we_n), .oe_n(oe_n),
    .burst_ileave(burst_ileave), .sleep(sleep), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe));

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    logic [DW-1:0] x;
    x = 36'h9A5C31E7B ^ (DW'(a) * 36'h043210FED) ^ (DW'(salt) * 36'h5A5A5A5A5);
    return x;
  endfunction

  task automatic dflt();
    strobe_p_n = 1; strobe_c_n = 1; adv_n = 1; cs_n = 0; cs_hi = 1; cs_lo_n = 0;
    wr_all_n = 1; wr_lane_en_n = 1; lane_we_n = 4'hF; oe_n = 0; dq_in = '0; addr = '0;
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic chk_rd(input string req, input logic [DW-1:0] exp);
    checks++;
    if (dq_oe !== 1'b1 || dq_out !== exp) begin
      fails++;
      $display("FAIL %s: dq_oe=%0b dq_out=%h expected dq_oe=1 dq_out=%h", req, dq_oe, dq_out, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    checks++;
    if (dq_oe !== 1'b0) begin
      fails++;
      $display("FAIL %s: dq_oe=%0b expected 0", req, dq_oe);
    end
  endtask

  task automatic deselect();
    dflt(); strobe_c_n = 0; cs_hi = 0;
  endtask

  task automatic rdback(input int lo, input int hi, input string req);
    for (int a = lo; a <= hi; a++) begin
      dflt(); addr = AW'(a); strobe_c_n = 0; tick();
      if (a > lo) chk_rd(req, model[a-1]);
    end
    deselect(); tick(); chk_rd(req, model[hi]);
    dflt(); tick(); chk_idle("R2");
  endtask

  task automatic burst(input int b, input bit ileave);
    int off;
    burst_ileave = ileave;
    dflt(); addr = AW'(b); strobe_c_n = 0; tick();
    for (int i = 0; i < 4; i++) begin
      if (i < 3) begin dflt(); adv_n = 0; end else deselect();
      tick();
      off = ileave ? ((b & 3) ^ i) : (((b & 3) + i) & 3);
      chk_rd(ileave ? "R5" : "R6", model[(b & ~3) | off]);
    end
    dflt(); tick(); chk_idle("R2");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    dflt(); burst_ileave = 1; sleep = 0;
    repeat (3) tick();
    rst_n = 1;
    chk_idle("R13");
    tick(); chk_idle("R13");

    // R7 fill with global writes; R10 no data after write cycles
    for (int a = 0; a < 64; a++) begin
      dflt(); addr = AW'(a); strobe_c_n = 0; wr_all_n = 0; dq_in = pat(a, 0);
      model[a] = pat(a, 0); tick();
      if (a > 0) chk_idle("R10");
    end
    deselect(); tick(); chk_idle("R10");
    rdback(0, 63, "R1 R7");

    // R5 / R6 burst orders from every offset
    for (int o = 0; o < 4; o++) burst(8 + o, 1);
    for (int o = 0; o < 4; o++) burst(20 + o, 0);
    burst_ileave = 1;

    // R8 every lane mask
    for (int m = 0; m < 16; m++) begin
      int a = 40 + m;
      dflt(); addr = AW'(a); strobe_c_n = 0; wr_all_n = 0; dq_in = pat(a, 1); tick();
      model[a] = pat(a, 1);
      dflt(); addr = AW'(a); strobe_c_n = 0; wr_lane_en_n = 0; lane_we_n = ~4'(m);
      dq_in = pat(a, 2); tick();
      for (int k = 0; k < 4; k++)
        if (m[k]) model[a][k*9 +: 9] = pat(a, 2) >> (k*9);
      deselect(); tick();
      if (m == 0) chk_rd("R8", model[a]); else chk_idle("R8");
      dflt(); tick();
    end
    rdback(40, 55, "R8");

    // R9 lane enables without byte-write enable
    for (int a = 56; a < 60; a++) begin
      dflt(); addr = AW'(a); strobe_c_n = 0; lane_we_n = 4'h0; dq_in = ~pat(a, 0); tick();
      deselect(); tick(); chk_rd("R9", model[a]);
      dflt(); tick();
    end
    rdback(56, 59, "R9");

    // R4 suspend then advance
    dflt(); addr = 6'd12; strobe_c_n = 0; tick();
    dflt(); tick(); chk_rd("R4", model[12]);
    dflt(); adv_n = 0; tick(); chk_rd("R4", model[12]);
    deselect(); tick(); chk_rd("R4", model[13]);
    dflt(); tick(); chk_idle("R4");

    // R3 processor strobe ignored with cs_n high
    dflt(); addr = 6'd16; strobe_c_n = 0; tick();
    dflt(); adv_n = 0; strobe_p_n = 0; cs_n = 1; addr = 6'd33; tick(); chk_rd("R3", model[16]);
    deselect(); tick(); chk_rd("R3", model[17]);
    dflt(); strobe_p_n = 0; cs_n = 1; addr = 6'd33; tick(); chk_idle("R3");
    dflt(); tick(); chk_idle("R3");

    // R1 / R2 processor strobe load and deselect
    dflt(); addr = 6'd30; strobe_p_n = 0; tick();
    dflt(); strobe_p_n = 0; cs_hi = 0; tick(); chk_rd("R1", model[30]);
    dflt(); adv_n = 0; tick(); chk_idle("R2");
    dflt(); adv_n = 0; tick(); chk_idle("R2");

    // R11 asynchronous output enable
    dflt(); addr = 6'd5; strobe_c_n = 0; tick();
    dflt(); tick(); chk_rd("R11", model[5]);
    oe_n = 1; #1 chk_idle("R11");
    oe_n = 0; #1 chk_rd("R11", model[5]);
    deselect(); tick(); dflt(); tick(); chk_idle("R11");

    // R12 sleep
    dflt(); addr = 6'd7; strobe_c_n = 0; tick();
    dflt(); adv_n = 0; tick(); chk_rd("R12", model[7]);
    sleep = 1; #1 chk_idle("R12");
    dflt(); addr = 6'd7; strobe_c_n = 0; wr_all_n = 0; dq_in = '1; tick(); chk_idle("R12");
    tick(); chk_idle("R12");
    sleep = 0; dflt(); adv_n = 0; tick(); chk_idle("R12");
    tick(); chk_idle("R12");
    rdback(6, 7, "R12");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule